// File: doc/BRIEF.md
# Load Result Alignment and Writeback Unit

This unit sits at the end of a core's load/store path. For each memory operation it receives the raw 32-bit word returned by memory, the low address bits, the destination register index and the base-register writeback from address generation. From these it produces the value for the register file. A word read from an unaligned address is rotated rather than faulted. A byte is taken from its lane and zero-extended. A load whose destination is the program counter is turned into a jump request instead of a register write.

The unit has two register-file write ports that are valid in the same cycle: a base port and a load port. The register file applies the base port first and the load port second. When a load targets the same register as the base writeback, the unit drops the base write, so the loaded value (or the jump) is the one that takes effect. Each accepted operation also yields an estimate of its cost in cycles. The estimate is built from per-class cycle weights given as parameters, plus a wait-state count supplied with the operation. All outputs are registered and appear one clock after the operation is presented.

Top module: `ldwb_unit`

## Requirements
- R1: After reset, `rf_we`, `bwb_we`, `jump_req` and `cost_valid` are all low.
- R2: A word load (`in_kind` = 2'b01) to a register other than 15 drives `rf_we` high one cycle later. `rf_data` then holds `mem_rdata` rotated right by 8 × `addr_lo` bits, and `rf_idx` equals `dst_idx`.
- R3: A byte load (`in_kind` = 2'b10) to a register other than 15 writes bits [8·`addr_lo`+7 : 8·`addr_lo`] of `mem_rdata` into `rf_data`[7:0], with all upper bits zero.
- R4: A load of either size with `dst_idx` = 15 raises `jump_req` one cycle later with `rf_we` low. `jump_target` carries the aligned value that R2 or R3 would have written.
- R5: With parameter `CLEAR_BIT0` = 1, bit 0 of `jump_target` is forced to zero. With `CLEAR_BIT0` = 0, it is passed unchanged.
- R6: A store (`in_kind` = 2'b00) causes no register write and no jump. Its cost is 2·`W_NSEQ` + `wait_cycles`.
- R7: A load to a register other than 15 costs `W_SEQ` + `W_NSEQ` + `W_INT` + `wait_cycles`.
- R8: A load to register 15 costs 2·`W_SEQ` + 2·`W_NSEQ` + `W_INT` + `wait_cycles`.
- R9: For any valid operation with code 00, 01 or 10, a base writeback request (`base_we_in`) is passed through one cycle later on `bwb_we`/`bwb_idx`/`bwb_data`, except as R10 states.
- R10: When a load's `base_idx_in` equals its `dst_idx`, `bwb_we` stays low and only the load result (or the jump) is issued.
- R11: When `in_valid` is low, or when `in_kind` = 2'b11, all four output enables are low in the next cycle, whatever the other inputs are.
- R12: `cost_valid` is high exactly one cycle after each valid operation with code 00, 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation present this cycle |
| in_kind | input | 2 | 00 store, 01 word load, 10 byte load, 11 no operation |
| mem_rdata | input | DW | Raw word returned by memory |
| addr_lo | input | log2(DW/8) | Low address bits (byte offset) |
| dst_idx | input | RIDX_W | Destination register index |
| base_we_in | input | 1 | Base writeback requested |
| base_idx_in | input | RIDX_W | Base register index |
| base_data_in | input | DW | Updated base address |
| wait_cycles | input | WS_W | Memory wait states for this access |
| rf_we | output | 1 | Load-port write enable |
| rf_idx | output | RIDX_W | Load-port register index |
| rf_data | output | DW | Load-port write data |
| bwb_we | output | 1 | Base-port write enable (applied before the load port) |
| bwb_idx | output | RIDX_W | Base-port register index |
| bwb_data | output | DW | Base-port write data |
| jump_req | output | 1 | Loaded value is a branch target |
| jump_target | output | DW | Branch target |
| cost_valid | output | 1 | Cost estimate valid |
| cost | output | COST_W | Cycle-cost estimate |

## Verification
The bench sweeps every operation code against every byte offset, every destination register, colliding and non-colliding base indices, and low, middle and maximum wait counts. Expected values come from shift arithmetic in the bench. A rotate in the wrong direction, or a byte taken from lane 0, shows up as wrong data at every non-zero offset. A unit that treats register 15 as an ordinary destination either raises no jump or charges the normal-load cost. A unit that lets the base write through on a collision is caught because `bwb_we` stays high with the same index. A second instance built with `CLEAR_BIT0` = 0 is checked against odd targets, so both settings of the bit-0 rule are covered.

// File: rtl/ldwb_pkg.sv
package ldwb_pkg;
  typedef enum logic [1:0] {
    K_STORE  = 2'b00,
    K_LDWORD = 2'b01,
    K_LDBYTE = 2'b10,
    K_NOP    = 2'b11
  } kind_t;

  typedef enum logic [1:0] {
    CL_STORE = 2'b00,
    CL_LOAD  = 2'b01,
    CL_JUMP  = 2'b10,
    CL_NONE  = 2'b11
  } cost_class_t;
endpackage

// File: rtl/ldwb_align.sv
module ldwb_align #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]             data_i,
  input  logic [$clog2(DW/8)-1:0]   lane_i,
  input  logic                      byte_mode_i,
  output logic [DW-1:0]             value_o
);
  localparam int LANES = DW / 8;

  logic [DW-1:0] rot [LANES];

  // one rotated copy per possible byte offset
  for (genvar k = 0; k < LANES; k++) begin : g_rot
    if (k == 0) begin : g_zero
      assign rot[k] = data_i;
    end else begin : g_shift
      assign rot[k] = {data_i[8*k-1:0], data_i[DW-1:8*k]};
    end
  end

  always_comb begin
    if (byte_mode_i) value_o = {{(DW-8){1'b0}}, rot[lane_i][7:0]};
    else             value_o = rot[lane_i];
  end
endmodule

// File: rtl/ldwb_route.sv
module ldwb_route
  import ldwb_pkg::*;
#(
  parameter int DW         = 32,
  parameter int RIDX_W     = 4,
  parameter bit CLEAR_BIT0 = 1'b1
) (
  input  kind_t              kind_i,
  input  logic [RIDX_W-1:0]  dst_idx_i,
  input  logic               base_req_i,
  input  logic [RIDX_W-1:0]  base_idx_i,
  input  logic [DW-1:0]      value_i,
  output logic               ld_we_o,
  output logic               jump_o,
  output logic               base_we_o,
  output cost_class_t        cls_o,
  output logic [DW-1:0]      target_o
);
  localparam logic [RIDX_W-1:0] PC_IDX = {RIDX_W{1'b1}};

  logic is_load, to_pc, collide;

  always_comb begin
    is_load   = (kind_i == K_LDWORD) || (kind_i == K_LDBYTE);
    to_pc     = (dst_idx_i == PC_IDX);
    collide   = is_load && (base_idx_i == dst_idx_i);
    ld_we_o   = is_load && !to_pc;
    jump_o    = is_load && to_pc;
    base_we_o = base_req_i && (kind_i != K_NOP) && !collide;
    if (kind_i == K_STORE)  cls_o = CL_STORE;
    else if (jump_o)        cls_o = CL_JUMP;
    else if (is_load)       cls_o = CL_LOAD;
    else                    cls_o = CL_NONE;
  end

  if (CLEAR_BIT0) begin : g_clr
    assign target_o = {value_i[DW-1:1], 1'b0};
  end else begin : g_keep
    assign target_o = value_i;
  end
endmodule

// File: rtl/ldwb_cost.sv
module ldwb_cost
  import ldwb_pkg::*;
#(
  parameter int COST_W = 6,
  parameter int WS_W   = 4,
  parameter int W_SEQ  = 1,
  parameter int W_NSEQ = 1,
  parameter int W_INT  = 1
) (
  input  cost_class_t        cls_i,
  input  logic [WS_W-1:0]    ws_i,
  output logic [COST_W-1:0]  cost_o
);
  localparam int C_STORE = 2 * W_NSEQ;
  localparam int C_LOAD  = W_SEQ + W_NSEQ + W_INT;
  localparam int C_JUMP  = 2 * W_SEQ + 2 * W_NSEQ + W_INT;

  logic [COST_W-1:0] base_c;

  always_comb begin
    case (cls_i)
      CL_STORE: base_c = COST_W'(C_STORE);
      CL_LOAD:  base_c = COST_W'(C_LOAD);
      CL_JUMP:  base_c = COST_W'(C_JUMP);
      default:  base_c = '0;
    endcase
    cost_o = base_c + COST_W'(ws_i);
  end
endmodule

// File: rtl/ldwb_unit.sv
module ldwb_unit
  import ldwb_pkg::*;
#(
  parameter int DW         = 32,
  parameter int RIDX_W     = 4,
  parameter int WS_W       = 4,
  parameter int COST_W     = 6,
  parameter int W_SEQ      = 1,
  parameter int W_NSEQ     = 1,
  parameter int W_INT      = 1,
  parameter bit CLEAR_BIT0 = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               in_kind,
  input  logic [DW-1:0]            mem_rdata,
  input  logic [$clog2(DW/8)-1:0]  addr_lo,
  input  logic [RIDX_W-1:0]        dst_idx,
  input  logic                     base_we_in,
  input  logic [RIDX_W-1:0]        base_idx_in,
  input  logic [DW-1:0]            base_data_in,
  input  logic [WS_W-1:0]          wait_cycles,
  output logic                     rf_we,
  output logic [RIDX_W-1:0]        rf_idx,
  output logic [DW-1:0]            rf_data,
  output logic                     bwb_we,
  output logic [RIDX_W-1:0]        bwb_idx,
  output logic [DW-1:0]            bwb_data,
  output logic                     jump_req,
  output logic [DW-1:0]            jump_target,
  output logic                     cost_valid,
  output logic [COST_W-1:0]        cost
);
  localparam logic [RIDX_W-1:0] PC_IDX   = {RIDX_W{1'b1}};
  localparam int                MIN_COST = (2 * W_NSEQ < W_SEQ + W_NSEQ + W_INT)
                                           ? 2 * W_NSEQ : W_SEQ + W_NSEQ + W_INT;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  kind_t         kind;
  logic [DW-1:0] aligned, target;
  logic          r_ld_we, r_jump, r_base_we;
  cost_class_t   cls;
  logic [COST_W-1:0] cost_n;

  assign kind = kind_t'(in_kind);

  ldwb_align #(.DW(DW)) u_align (
    .data_i      (mem_rdata),
    .lane_i      (addr_lo),
    .byte_mode_i (kind == K_LDBYTE),
    .value_o     (aligned)
  );

  ldwb_route #(.DW(DW), .RIDX_W(RIDX_W), .CLEAR_BIT0(CLEAR_BIT0)) u_route (
    .kind_i     (kind),
    .dst_idx_i  (dst_idx),
    .base_req_i (base_we_in),
    .base_idx_i (base_idx_in),
    .value_i    (aligned),
    .ld_we_o    (r_ld_we),
    .jump_o     (r_jump),
    .base_we_o  (r_base_we),
    .cls_o      (cls),
    .target_o   (target)
  );

  ldwb_cost #(.COST_W(COST_W), .WS_W(WS_W), .W_SEQ(W_SEQ),
              .W_NSEQ(W_NSEQ), .W_INT(W_INT)) u_cost (
    .cls_i  (cls),
    .ws_i   (wait_cycles),
    .cost_o (cost_n)
  );

  // next state
  logic rf_we_n, bwb_we_n, jump_n, cv_n, load_en;
  always_comb begin
    load_en  = in_valid;
    rf_we_n  = in_valid && r_ld_we;
    bwb_we_n = in_valid && r_base_we;
    jump_n   = in_valid && r_jump;
    cv_n     = in_valid && (kind != K_NOP);
  end

  // enables: every cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rf_we      <= 1'b0;
      bwb_we     <= 1'b0;
      jump_req   <= 1'b0;
      cost_valid <= 1'b0;
    end else begin
      rf_we      <= rf_we_n;
      bwb_we     <= bwb_we_n;
      jump_req   <= jump_n;
      cost_valid <= cv_n;
    end
  end

  // payload: only on an accepted operation
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rf_idx      <= '0;
      rf_data     <= '0;
      bwb_idx     <= '0;
      bwb_data    <= '0;
      jump_target <= '0;
      cost        <= '0;
    end else if (load_en) begin
      rf_idx      <= dst_idx;
      rf_data     <= aligned;
      bwb_idx     <= base_idx_in;
      bwb_data    <= base_data_in;
      jump_target <= target;
      cost        <= cost_n;
    end
  end

  // checks
  assert_jump_excl_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    jump_req |-> !rf_we);

  if (CLEAR_BIT0) begin : g_chk_clr
    assert_jump_even_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      jump_req |-> !jump_target[0]);
  end

  assert_no_collide_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rf_we && bwb_we) |-> (rf_idx != bwb_idx));

  assert_jump_wins_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (jump_req && bwb_we) |-> (bwb_idx != PC_IDX));

  assert_store_quiet_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_kind == 2'b00) |=> (cost_valid && !rf_we && !jump_req));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_valid || in_kind == 2'b11) |=> (!cost_valid && !rf_we && !bwb_we && !jump_req));

  assert_cost_floor_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cost_valid |-> (cost >= COST_W'(MIN_COST)));
endmodule

// File: tb/tb_ldwb_unit.sv
module tb_ldwb_unit;
  localparam int WS = 1, WN = 1, WI = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_kind;
  logic [31:0] mem_rdata;
  logic [1:0]  addr_lo;
  logic [3:0]  dst_idx;
  logic        base_we_in;
  logic [3:0]  base_idx_in;
  logic [31:0] base_data_in;
  logic [3:0]  wait_cycles;

  logic        rf_we, bwb_we, jump_req, cost_valid;
  logic [3:0]  rf_idx, bwb_idx;
  logic [31:0] rf_data, bwb_data, jump_target;
  logic [5:0]  cost;
  logic        k_rf_we, k_bwb_we, k_jump_req, k_cost_valid;
  logic [3:0]  k_rf_idx, k_bwb_idx;
  logic [31:0] k_rf_data, k_bwb_data, k_jump_target;
  logic [5:0]  k_cost;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ldwb_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .mem_rdata(mem_rdata), .addr_lo(addr_lo), .dst_idx(dst_idx),
    .base_we_in(base_we_in), .base_idx_in(base_idx_in), .base_data_in(base_data_in),
    .wait_cycles(wait_cycles), .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
    .bwb_we(bwb_we), .bwb_idx(bwb_idx), .bwb_data(bwb_data), .jump_req(jump_req),
    .jump_target(jump_target), .cost_valid(cost_valid), .cost(cost)
  );

  ldwb_unit #(.CLEAR_BIT0(1'b0)) dut_keep (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .mem_rdata(mem_rdata), .addr_lo(addr_lo), .dst_idx(dst_idx),
    .base_we_in(base_we_in), .base_idx_in(base_idx_in), .base_data_in(base_data_in),
    .wait_cycles(wait_cycles), .rf_we(k_rf_we), .rf_idx(k_rf_idx), .rf_data(k_rf_data),
    .bwb_we(k_bwb_we), .bwb_idx(k_bwb_idx), .bwb_data(k_bwb_data), .jump_req(k_jump_req),
    .jump_target(k_jump_target), .cost_valid(k_cost_valid), .cost(k_cost)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ror8(input logic [31:0] d, input int a);
    logic [63:0] t;
    t = {d, d} >> (8 * a);
    return t[31:0];
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic run_op(input bit v, input logic [1:0] k, input logic [31:0] d,
                        input int a, input int dst, input bit bwe, input int bidx,
                        input int ws);
    logic [31:0] val, expc;
    bit is_ld, to_pc, exp_bwe;
    in_valid     = v;
    in_kind      = k;
    mem_rdata    = d;
    addr_lo      = 2'(a);
    dst_idx      = 4'(dst);
    base_we_in   = bwe;
    base_idx_in  = 4'(bidx);
    base_data_in = d ^ 32'h5A5A_0F0F;
    wait_cycles  = 4'(ws);
    @(negedge clk);
    is_ld = v && (k == 2'b01 || k == 2'b10);
    to_pc = (dst == 15);
    val   = (k == 2'b10) ? ((d >> (8 * a)) & 32'hFF) : ror8(d, a);
    if (!v || k == 2'b11) begin
      chk(!rf_we && !bwb_we && !jump_req && !cost_valid, "R11 idle enables",
          {28'd0, rf_we, bwb_we, jump_req, cost_valid}, 32'd0);
    end else begin
      chk(cost_valid, "R12 cost_valid", {31'd0, cost_valid}, 32'd1);
      if (k == 2'b00)      expc = 32'(2 * WN + ws);
      else if (to_pc)      expc = 32'(2 * WS + 2 * WN + WI + ws);
      else                 expc = 32'(WS + WN + WI + ws);
      chk(cost == expc[5:0], k == 2'b00 ? "R6 store cost" : (to_pc ? "R8 jump cost" : "R7 load cost"),
          {26'd0, cost}, expc);
      if (k == 2'b00)
        chk(!rf_we && !jump_req, "R6 store writes nothing", {30'd0, rf_we, jump_req}, 32'd0);
      else if (to_pc) begin
        chk(jump_req && !rf_we, "R4 jump instead of write", {30'd0, jump_req, rf_we}, 32'd2);
        chk(jump_target == (val & 32'hFFFF_FFFE), "R5 target bit0 cleared", jump_target,
            val & 32'hFFFF_FFFE);
        chk(k_jump_target == val, "R5 target bit0 kept", k_jump_target, val);
      end else begin
        chk(rf_we && !jump_req && rf_idx == 4'(dst), "R2 write enable/index",
            {27'd0, rf_we, rf_idx}, {27'd0, 1'b1, 4'(dst)});
        chk(rf_data == val, k == 2'b10 ? "R3 byte zero-extend" : "R2 word rotate", rf_data, val);
      end
      exp_bwe = bwe && !(is_ld && bidx == dst);
      chk(bwb_we == exp_bwe, exp_bwe || !bwe ? "R9 base pass" : "R10 base dropped",
          {31'd0, bwb_we}, {31'd0, exp_bwe});
      if (exp_bwe)
        chk(bwb_idx == 4'(bidx) && bwb_data == (d ^ 32'h5A5A_0F0F), "R9 base payload",
            bwb_data, d ^ 32'h5A5A_0F0F);
    end
  endtask

  initial begin
    int n;
    n = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_kind = 2'b00; mem_rdata = '0; addr_lo = '0;
    dst_idx = '0; base_we_in = 1'b0; base_idx_in = '0; base_data_in = '0; wait_cycles = '0;
    repeat (3) @(negedge clk);
    chk(!rf_we && !bwb_we && !jump_req && !cost_valid, "R1 reset state",
        {28'd0, rf_we, bwb_we, jump_req, cost_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rf_we && !bwb_we && !jump_req && !cost_valid, "R1 after release",
        {28'd0, rf_we, bwb_we, jump_req, cost_valid}, 32'd0);

    // directed: odd bytes in every lane, word and byte jumps
    for (int a = 0; a < 4; a++) begin
      run_op(1'b1, 2'b01, 32'h8B6D_4F21, a, 15, 1'b1, 3, 0);
      run_op(1'b1, 2'b10, 32'h8B6D_4F21, a, 15, 1'b1, 15, 15);
    end
    // idle with junk inputs
    run_op(1'b0, 2'b01, 32'hFFFF_FFFF, 1, 2, 1'b1, 5, 9);

    // sweep
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 4; a++)
        for (int dst = 0; dst < 16; dst++)
          for (int b = 0; b < 4; b++)
            for (int w = 0; w < 3; w++) begin
              n++;
              run_op(1'b1, 2'(k), 32'h9E37_79B9 * 32'(n) + 32'h0101_0301, a, dst,
                     b[0], b[1] ? dst : (dst + 1) % 16, w * 7 + (w == 2 ? 1 : 0));
            end
    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule